// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block models the target side of a two-wire serial EEPROM as synthesizable logic. A free-running system clock oversamples the bus clock and data lines through two-flop synchronizers. The block pulls the shared open-drain data line low through an output-enable, which the pad or bench combines with the pull-up. One parameter selects the storage size, from 128 to 2048 bytes. The page size, the word-address width and the set of hard-wired address pins compared during device selection all follow from that size.

A master starts a command with a START. It then sends a device-select byte made of a fixed type code, the pin or upper-address bits, and a direction bit. For a write, the master sends a word address and one or more data bytes, and ends with a STOP. The received bytes wait in a page buffer and are copied into the array once a write delay, counted in system clocks, has run out. The block supports current-address reads, random reads (a dummy write followed by a repeated START) and sequential reads. A write-protect input blocks every change to the array.

Top module: `twi_eeprom_target`

## Requirements
- R1: After reset, the data output-enable is low, and the block stays silent until a START is seen.
- R2: A START (data falling while the bus clock is high) that arrives outside a write cycle aborts any transfer in progress. It restarts decoding with a device-select byte, and a partial byte received before it is discarded.
- R3: The device-select byte is `1010` in bits 7..4, followed by bits 3..1, followed by the direction bit in bit 0 (1 = read). Bits 3..1 correspond to address pins 2..0. A pin is compared only when the density does not use that position for address: all three pins at 128/256 bytes, pins 2..1 at 512, pin 2 at 1024, none at 2048. On a match the block acknowledges by driving data low during the ninth clock. On a mismatch it does not acknowledge.
- R4: Bytes move most-significant bit first. The block changes its data output only while the bus clock is low, after a falling edge.
- R5: After a STOP that ends a write of at least one data byte with write-protect low, the buffered bytes are written into the array once WR_DELAY system clocks have elapsed.
- R6: During a write, the low log2(page) address bits increment and wrap within the current page (8 bytes at 128/256, 16 bytes above). A partial page updates only the bytes sent.
- R7: A read without a preceding word address returns the byte at the internal address counter, which points one past the last byte read. A random read returns the byte at the word address sent in the dummy write.
- R8: While the master acknowledges each read byte, the address advances, rolling over from the last array location to 0.
- R9: While write-protect is high at the STOP, the array is not modified and no write cycle starts. Data bytes are still acknowledged.
- R10: During the write cycle a START is ignored, so the device-select byte is not acknowledged. Once the cycle is over, selection is acknowledged again.
- R11: When the master does not acknowledge a read byte, the block releases the data line and drives nothing until the next START.
- R12: At densities above 256 bytes, the select-byte positions that are not compared carry the upper word-address bits. Bit 1 is the lowest of these (address bit 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Data line level as seen on the bus, asynchronous |
| addr_pins_i | input | 3 | Hard-wired device address pins 2..0 |
| wp_i | input | 1 | Write protect, high blocks array changes |
| sda_oe_o | output | 1 | High pulls the data line low |

## Verification
The hardest cases to reach are a START that lands inside the self-timed write cycle and a START that cuts a data byte in half. Both need bus sequences that a well-formed master rarely produces. For the first, the bench issues a complete select attempt immediately after the STOP that ends a write. The delay is long enough for the whole attempt to fit inside it, so the attempt is refused. The bench then waits out the delay and repeats the attempt, which is accepted. For the second, the bench stops after four data bits, raises a START, and sends a read select. A buffered or committed byte would show up as a refused select or as wrong read data.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DEVSEL = 3'd1,
        ST_WADDR  = 3'd2,
        ST_WDATA  = 3'd3,
        ST_READ   = 3'd4
    } twi_state_e;

    localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;

    function automatic int page_bytes(input int mem_bytes);
        return (mem_bytes <= 256) ? 8 : 16;
    endfunction

    function automatic int upper_addr_bits(input int addr_bits);
        return (addr_bits > 8) ? addr_bits - 8 : 0;
    endfunction

endpackage

// File: rtl/twi_bus_monitor.sv
module twi_bus_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [2:0] scl;
        logic [2:0] sda;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d     = sync_q;
        sync_d.scl = {sync_q.scl[1:0], scl_i};
        sync_d.sda = {sync_q.sda[1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '{scl: 3'b111, sda: 3'b111};
        else        sync_q <= sync_d;
    end

    logic scl_s, scl_p, sda_s, sda_p;
    assign scl_s = sync_q.scl[1];
    assign scl_p = sync_q.scl[2];
    assign sda_s = sync_q.sda[1];
    assign sda_p = sync_q.sda[2];

    assign sda_s_o    = sda_s;
    assign scl_rise_o = scl_s & ~scl_p;
    assign scl_fall_o = ~scl_s & scl_p;
    assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/eeprom_write_timer.sv
module eeprom_write_timer #(
    parameter int DELAY = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(DELAY + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)              cnt_d = CW'(DELAY);
        else if (cnt_q != '0)     cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
    assign done_o = (cnt_q == CW'(1));

    // R5: a started write cycle is busy on the next clock
    assert_cycle_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
    // R5: the commit pulse ends the busy window
    assert_cycle_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !busy_o);

endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
    parameter int MEM_BYTES = 512,
    parameter int PAGE      = 16,
    parameter int AW        = 9,
    parameter int PW        = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr_i,
    output logic [7:0]    rd_data_o,
    input  logic          buf_clr_i,
    input  logic          buf_we_i,
    input  logic [PW-1:0] buf_off_i,
    input  logic [7:0]    buf_data_i,
    input  logic          commit_i,
    input  logic [AW-PW-1:0] commit_page_i
);
    logic [7:0]      mem_q [MEM_BYTES];
    logic [7:0]      buf_q [PAGE];
    logic [PAGE-1:0] val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
            for (int i = 0; i < PAGE; i++) buf_q[i] <= 8'h00;
        end else if (buf_clr_i) begin
            val_q <= '0;
        end else if (buf_we_i) begin
            buf_q[buf_off_i] <= buf_data_i;
            val_q[buf_off_i] <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= 8'hFF;
        end else if (commit_i) begin
            for (int i = 0; i < PAGE; i++) begin
                if (val_q[i]) mem_q[{commit_page_i, PW'(i)}] <= buf_q[i];
            end
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

    // R9: the array changes only on a commit pulse
    assert_mem_hold_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(mem_q[0]));
    assert_mem_hold_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(mem_q[MEM_BYTES-1]));

endmodule

// File: rtl/twi_eeprom_target.sv
module twi_eeprom_target
    import twi_eeprom_pkg::*;
#(
    parameter int MEM_BYTES = 512,
    parameter int WR_DELAY  = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] addr_pins_i,
    input  logic       wp_i,
    output logic       sda_oe_o
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int PAGE = page_bytes(MEM_BYTES);
    localparam int PW = $clog2(PAGE);
    localparam int UB = upper_addr_bits(AW);
    localparam logic [2:0] UMASK = 3'((1 << UB) - 1);
    localparam logic [2:0] CMASK = ~UMASK;

    typedef struct packed {
        twi_state_e    st;
        logic [3:0]    bitcnt;
        logic [7:0]    sh;
        logic          oe;
        logic [AW-1:0] addr;
        logic [2:0]    upper;
        logic          rd;
        logic          macked;
        logic          wpend;
    } ctl_t;

    logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic busy, commit, tmr_start;
    logic buf_clr, buf_we;
    logic [7:0] rd_data;
    ctl_t ctl_d, ctl_q;

    twi_bus_monitor u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_s_o    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_evt),
        .stop_o     (stop_evt)
    );

    eeprom_write_timer #(.DELAY(WR_DELAY)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .busy_o  (busy),
        .done_o  (commit)
    );

    eeprom_store #(.MEM_BYTES(MEM_BYTES), .PAGE(PAGE), .AW(AW), .PW(PW)) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_addr_i     (ctl_q.addr),
        .rd_data_o     (rd_data),
        .buf_clr_i     (buf_clr),
        .buf_we_i      (buf_we),
        .buf_off_i     (ctl_q.addr[PW-1:0]),
        .buf_data_i    (ctl_q.sh),
        .commit_i      (commit),
        .commit_page_i (ctl_q.addr[AW-1:PW])
    );

    logic sel_match;
    assign sel_match = (ctl_q.sh[7:4] == DEV_TYPE_CODE) &&
                       (((ctl_q.sh[3:1] ^ addr_pins_i) & CMASK) == 3'b000);

    always_comb begin
        ctl_d     = ctl_q;
        tmr_start = 1'b0;
        buf_clr   = 1'b0;
        buf_we    = 1'b0;
        if (stop_evt) begin
            ctl_d.st     = ST_IDLE;
            ctl_d.oe     = 1'b0;
            ctl_d.bitcnt = 4'd0;
            if (ctl_q.st == ST_WDATA && ctl_q.wpend && !wp_i) tmr_start = 1'b1;
        end else if (start_evt && !busy) begin
            ctl_d.st     = ST_DEVSEL;
            ctl_d.oe     = 1'b0;
            ctl_d.bitcnt = 4'd0;
            ctl_d.wpend  = 1'b0;
        end else if (ctl_q.st == ST_READ) begin
            if (scl_rise) begin
                if (ctl_q.bitcnt == 4'd8) ctl_d.macked = !sda_s;
                ctl_d.bitcnt = ctl_q.bitcnt + 4'd1;
            end else if (scl_fall) begin
                if (ctl_q.bitcnt < 4'd8) begin
                    ctl_d.sh = {ctl_q.sh[6:0], 1'b0};
                    ctl_d.oe = !ctl_q.sh[6];
                end else if (ctl_q.bitcnt == 4'd8) begin
                    ctl_d.oe   = 1'b0;
                    ctl_d.addr = ctl_q.addr + AW'(1);
                end else begin
                    ctl_d.bitcnt = 4'd0;
                    if (ctl_q.macked) begin
                        ctl_d.sh = rd_data;
                        ctl_d.oe = !rd_data[7];
                    end else begin
                        ctl_d.st = ST_IDLE;
                    end
                end
            end
        end else if (ctl_q.st != ST_IDLE) begin
            if (scl_rise) begin
                if (ctl_q.bitcnt < 4'd8) ctl_d.sh = {ctl_q.sh[6:0], sda_s};
                ctl_d.bitcnt = ctl_q.bitcnt + 4'd1;
            end else if (scl_fall && ctl_q.bitcnt == 4'd8) begin
                case (ctl_q.st)
                    ST_DEVSEL: begin
                        if (sel_match) begin
                            ctl_d.oe = 1'b1;
                            ctl_d.rd = ctl_q.sh[0];
                            if (!ctl_q.sh[0]) ctl_d.upper = ctl_q.sh[3:1] & UMASK;
                        end else begin
                            ctl_d.st     = ST_IDLE;
                            ctl_d.bitcnt = 4'd0;
                        end
                    end
                    ST_WADDR: begin
                        ctl_d.oe    = 1'b1;
                        ctl_d.addr  = AW'({ctl_q.upper, ctl_q.sh});
                        ctl_d.wpend = 1'b0;
                        buf_clr     = 1'b1;
                    end
                    default: begin
                        ctl_d.oe    = 1'b1;
                        ctl_d.wpend = 1'b1;
                        buf_we      = 1'b1;
                        ctl_d.addr  = {ctl_q.addr[AW-1:PW], ctl_q.addr[PW-1:0] + PW'(1)};
                    end
                endcase
            end else if (scl_fall && ctl_q.bitcnt == 4'd9) begin
                ctl_d.oe     = 1'b0;
                ctl_d.bitcnt = 4'd0;
                case (ctl_q.st)
                    ST_DEVSEL: begin
                        if (ctl_q.rd) begin
                            ctl_d.st = ST_READ;
                            ctl_d.sh = rd_data;
                            ctl_d.oe = !rd_data[7];
                        end else begin
                            ctl_d.st = ST_WADDR;
                        end
                    end
                    ST_WADDR: ctl_d.st = ST_WDATA;
                    default:  ctl_d.st = ctl_q.st;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, bitcnt: 4'd0, sh: 8'h00, oe: 1'b0,
                       addr: '0, upper: 3'b000, rd: 1'b0, macked: 1'b0, wpend: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sda_oe_o = ctl_q.oe;

    // R10: a START seen during the write cycle leaves the controller in standby
    assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_evt && !stop_evt) |=> ctl_q.st == ST_IDLE);
    // R11: standby never drives the line
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE) |-> !sda_oe_o);
    // R3: on receive the target drives only across the ninth clock
    assert_ack_on_ninth_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o && ctl_q.st != ST_READ) |-> ctl_q.bitcnt >= 4'd8);
    // R10: no write cycle is started while one is running
    assert_no_restart_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !tmr_start);

endmodule

// File: tb/twi_eeprom_target_tb_top.sv
module twi_eeprom_target_tb_top;
    localparam int MEM  = 512;
    localparam int WRD  = 1000;
    localparam int PAGE = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic [2:0] pins = 3'b101;
    logic sda_oe;
    logic sda_bus;

    assign sda_bus = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    twi_eeprom_target #(.MEM_BYTES(MEM), .WR_DELAY(WRD)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .addr_pins_i (pins),
        .wp_i        (wp),
        .sda_oe_o    (sda_oe)
    );

    int tests = 0;
    int fails = 0;
    int model [MEM];
    int cur = 0;
    logic may_drive = 1'b0;
    logic prev_oe = 1'b0;
    bit bad_drive = 1'b0;
    bit bad_edge = 1'b0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // per-clock reference comparison of the line driver
    always @(negedge clk) begin
        if (rst_n) begin
            if (sda_oe && !may_drive && !bad_drive) begin
                bad_drive = 1'b1;
                $display("FAIL R11 unexpected drive actual=1 expected=0 at %0t", $time);
            end
            if (scl_m && (sda_oe != prev_oe) && !bad_edge) begin
                bad_edge = 1'b1;
                $display("FAIL R4 data changed with clock high actual=%0b expected=%0b", sda_oe, prev_oe);
            end
        end
        prev_oe = sda_oe;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        report();
    end

    function automatic logic [7:0] dsel(input logic a8, input logic rd);
        return {4'b1010, pins[2], pins[1], a8, rd};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        wait_clk(6);
        may_drive = 1'b0;
        sda_m = b;
        wait_clk(4);
        scl_m = 1'b1;
        wait_clk(10);
        scl_m = 1'b0;
    endtask

    task automatic dev_bit(output logic v);
        may_drive = 1'b1;
        sda_m = 1'b1;
        wait_clk(10);
        scl_m = 1'b1;
        wait_clk(5);
        v = sda_bus;
        wait_clk(5);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic v;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        dev_bit(v);
        ack = !v;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            dev_bit(v);
            b[i] = v;
        end
        send_bit(!mack);
    endtask

    task automatic start_c();
        wait_clk(6);
        may_drive = 1'b0;
        sda_m = 1'b1;
        wait_clk(4);
        scl_m = 1'b1;
        wait_clk(10);
        sda_m = 1'b0;
        wait_clk(10);
        scl_m = 1'b0;
    endtask

    task automatic stop_c();
        wait_clk(6);
        may_drive = 1'b0;
        sda_m = 1'b0;
        wait_clk(4);
        scl_m = 1'b1;
        wait_clk(10);
        sda_m = 1'b1;
        wait_clk(10);
    endtask

    task automatic do_write(input int base, input logic [7:0] d[$], input string req);
        logic a;
        start_c();
        send_byte(dsel(base[8], 1'b0), a);
        check(a, {req, " R3 select ack"}, a, 1);
        send_byte(base[7:0], a);
        check(a, {req, " word address ack"}, a, 1);
        foreach (d[i]) begin
            send_byte(d[i], a);
            check(a, {req, " data ack"}, a, 1);
        end
        stop_c();
        if (!wp) begin
            foreach (d[i]) model[(base & ~(PAGE - 1)) | ((base + i) % PAGE)] = d[i];
        end
    endtask

    task automatic do_read(input int base, input int n, input bit random, input string req);
        logic a;
        logic [7:0] b;
        int start_addr;
        start_addr = random ? base : cur;
        start_c();
        if (random) begin
            send_byte(dsel(base[8], 1'b0), a);
            check(a, {req, " R7 dummy select ack"}, a, 1);
            send_byte(base[7:0], a);
            check(a, {req, " R7 address ack"}, a, 1);
            start_c();
        end
        send_byte(dsel(1'b0, 1'b1), a);
        check(a, {req, " R3 read select ack"}, a, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(b, k < n - 1);
            check(b == 8'(model[(start_addr + k) % MEM]), req, b, model[(start_addr + k) % MEM]);
        end
        wait_clk(8);
        check(!sda_oe, "R11 released after master nack", sda_oe, 0);
        stop_c();
        cur = (start_addr + n) % MEM;
    endtask

    task automatic probe(input bit exp_ack, input logic [7:0] sel, input string req);
        logic a;
        start_c();
        send_byte(sel, a);
        check(a == exp_ack, req, a, exp_ack);
        stop_c();
    endtask

    initial begin
        logic a;
        logic [7:0] b;
        for (int i = 0; i < MEM; i++) model[i] = 8'hFF;
        wait_clk(5);
        check(!sda_oe, "R1 reset output-enable", sda_oe, 0);
        rst_n = 1'b1;
        wait_clk(10);
        check(!sda_oe, "R1 idle after reset", sda_oe, 0);

        // R5 byte write, then R10 busy window
        do_write(0, '{8'h11, 8'hA5, 8'h5A}, "R5 write at 0");
        probe(1'b0, dsel(1'b0, 1'b0), "R10 select refused while busy");
        wait_clk(WRD + 100);
        probe(1'b1, dsel(1'b0, 1'b0), "R10 select accepted after cycle");

        // R7 random then current-address read
        do_read(1, 1, 1'b1, "R7 random read");
        do_read(0, 1, 1'b0, "R7 current address read");

        // R6 / R12 page write wrapping in the upper half
        do_write(9'h1FC, '{8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5}, "R6 R12 page write");
        wait_clk(WRD + 100);
        do_read(9'h1F0, 16, 1'b1, "R6 R12 page contents");

        // R8 sequential rollover
        do_read(9'h1FE, 4, 1'b1, "R8 rollover read");

        // R9 write protect
        wp = 1'b1;
        do_write(9'h040, '{8'h33}, "R9 protected write");
        wp = 1'b0;
        probe(1'b1, dsel(1'b0, 1'b0), "R9 no write cycle started");
        do_read(9'h040, 1, 1'b1, "R9 array unchanged");

        // R3 select mismatches
        probe(1'b0, {4'b1010, 2'b11, 1'b0, 1'b0}, "R3 pin mismatch nack");
        probe(1'b0, {4'b1011, pins[2], pins[1], 1'b0, 1'b0}, "R3 type code mismatch nack");
        probe(1'b1, {4'b1010, pins[2], pins[1], 1'b1, 1'b0}, "R12 upper bit not compared");

        // R2 START mid byte aborts and restarts decoding
        start_c();
        send_byte(dsel(1'b0, 1'b0), a);
        check(a, "R2 select ack", a, 1);
        send_byte(8'h50, a);
        check(a, "R2 address ack", a, 1);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        start_c();
        send_byte(dsel(1'b0, 1'b1), a);
        check(a, "R2 restart read select ack", a, 1);
        recv_byte(b, 1'b0);
        check(b == 8'(model[9'h050]), "R2 read after abort", b, model[9'h050]);
        stop_c();
        wait_clk(20);
        probe(1'b1, dsel(1'b0, 1'b0), "R2 no write cycle after abort");

        check(!bad_drive, "R11 drive only in allowed windows", bad_drive, 0);
        check(!bad_edge, "R4 output changes only with clock low", bad_edge, 0);
        report();
    end

endmodule